// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the transfer registers for four DMA channels. Each channel has a 16-bit start address and start count, plus a working address and a working count. A host programs the start registers one byte at a time through an 8-bit port. A byte pointer picks the low or high half of each register. Every host write to the start registers also loads the working registers with the same value. Once a service has begun, the start registers are not changed by transfers.

A separate transfer sequencer (not part of this block) drives a one-cycle step pulse for each completed transfer, together with the channel number. On each step the unit moves the working address up or down by one and decrements the working count. A step taken at a count of zero wraps the count to FFFFH; this is the terminal count. On terminal count the unit sets the channel's status bit and pulses an end-of-process output. It then either masks the channel or, when auto-reload is selected, copies the start registers back into the working ones.

An external end-of-process flag that arrives with a step also ends the service. In memory-to-memory mode, channel 0 acts as the source and is handled differently. A page flag tells the sequencer when the high address byte has changed and must be latched again.

Top module: `dmac_addr_count_unit`

## Requirements
- R1: After reset, or after a host write to select 0xC (master clear), all mask bits are 1 and all terminal-count bits are 0. The byte pointer selects the low byte, and the channel modes and the command register are cleared. `eop_o` and `page_o` are 0 after reset.
- R2: Selects 0x0..0x7 address a channel register. Bits [2:1] give the channel and bit 0 picks count (1) or address (0). A host write loads the byte chosen by the pointer into both the start register and the working register. A host read returns that byte of the working register.
- R3: Every host read or write of a channel register toggles the byte pointer. A write to select 0xA clears the pointer (low byte next) and a write to select 0xB sets it (high byte next).
- R4: A step on a channel decrements the working count by 1. It also moves the working address by +1, or by -1 when the direction bit is set. Mode writes use select 0x8: data[1:0] is the channel, data[3] is the direction (1 = down), and data[4] is auto-reload.
- R5: A step taken while the working count is 0000H leaves FFFFH (unless reloaded). It sets the channel's terminal-count bit and makes `eop_o` high for exactly the cycle after that step.
- R6: Without auto-reload, the end of a service sets the channel's mask bit and leaves the stepped values in the working registers. A service ends on terminal count or on a step with `xfer_ext_eop` high.
- R7: With auto-reload, the end of a service copies the start address and start count into the working registers and leaves the mask bit unchanged.
- R8: A step with `xfer_ext_eop` high ends the service as in R6/R7. It still applies the normal step when there is no reload, and it does not set the terminal-count bit or pulse `eop_o`.
- R9: With memory-to-memory enabled (command data[0], select 0x9), channel 0 is the source. Its wrap never sets its terminal-count bit, pulses `eop_o` or sets its mask, and only reloads it when auto-reload is on. `xfer_ext_eop` on a channel-0 step has no effect.
- R10: With memory-to-memory and command data[1] both set, channel 0's working address stays constant on every step.
- R11: `page_o` is high for the cycle after any step whose new working address has a different high byte from the old one.
- R12: A host read of select 0xD returns {mask[3:0], tc[3:0]}, channel n at bit n of each nibble. The read clears all terminal-count bits.
- R13: A host write to select 0xD sets the mask bit of channel data[1:0] to data[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 4 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational from select and pointer) |
| xfer_step | input | 1 | One-cycle pulse: one transfer completed |
| xfer_ch | input | 2 | Channel the step applies to; also selects `cur_addr_o` |
| xfer_ext_eop | input | 1 | External end-of-process, qualified by `xfer_step` |
| cur_addr_o | output | 16 | Working address of channel `xfer_ch` |
| chan_mask_o | output | 4 | Mask bits, one per channel |
| eop_o | output | 1 | Terminal-count pulse, cycle after the step |
| page_o | output | 1 | High-byte-changed pulse, cycle after the step |

## Verification
The bench uses the default build: four channels with 16-bit registers and byte-wide host access. It programs small counts (2 to 5), so every channel reaches its wrap within a few steps. The sweep covers every channel, both directions and both reload settings. Start addresses sit just below or above a 256-byte line, so the page flag and the FFFFH wrap both appear in each run. Memory-to-memory hold, external end-of-process and the pointer commands are then exercised on top of that sweep.

// File: rtl/dmac_pkg.sv
// Shared sizes and host select codes for the DMA address/count unit.
// Assumes REG_W == 2*BYTE_W and four channels (select field is two bits).
package dmac_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;
    localparam int SEL_W  = 4;
    localparam int CTL_W  = 5;

    localparam logic [SEL_W-1:0] SEL_MODE    = 4'h8;
    localparam logic [SEL_W-1:0] SEL_CMD     = 4'h9;
    localparam logic [SEL_W-1:0] SEL_PTR_CLR = 4'hA;
    localparam logic [SEL_W-1:0] SEL_PTR_SET = 4'hB;
    localparam logic [SEL_W-1:0] SEL_MCLR    = 4'hC;
    localparam logic [SEL_W-1:0] SEL_MASK    = 4'hD;

    localparam int CTL_MASK_BIT = 2;
    localparam int CTL_DEC_BIT  = 3;
    localparam int CTL_AUTO_BIT = 4;
endpackage

// File: rtl/dmac_host_if.sv
// Host-side decode: byte pointer, command register and per-channel
// write strobes. Assumes one-cycle strobes and no overlap with steps.
module dmac_host_if
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [CTL_W-1:0]  ctl,
    output logic              ptr_hi,
    output logic              mclr,
    output logic              tc_clr,
    output logic              cmd_m2m,
    output logic              cmd_hold,
    output logic [NUM_CH-1:0] wr_addr_v,
    output logic [NUM_CH-1:0] wr_cnt_v,
    output logic [NUM_CH-1:0] mode_wr_v,
    output logic [NUM_CH-1:0] mask_wr_v,
    output logic              mode_dec,
    output logic              mode_auto,
    output logic              mask_val
);
    logic chan_acc;
    logic ptr_clr;
    logic ptr_set;

    // Decode strobes from select, strobe and control bits.
    always_comb begin
        chan_acc = (wr | rd) & ~sel[SEL_W-1];
        mclr     = wr & (sel == SEL_MCLR);
        tc_clr   = rd & (sel == SEL_MASK);
        ptr_clr  = wr & (sel == SEL_PTR_CLR);
        ptr_set  = wr & (sel == SEL_PTR_SET);
        for (int i = 0; i < NUM_CH; i++) begin
            wr_addr_v[i] = wr & ~sel[SEL_W-1] & (sel[CH_W:1] == CH_W'(i)) & ~sel[0];
            wr_cnt_v[i]  = wr & ~sel[SEL_W-1] & (sel[CH_W:1] == CH_W'(i)) &  sel[0];
            mode_wr_v[i] = wr & (sel == SEL_MODE) & (ctl[CH_W-1:0] == CH_W'(i));
            mask_wr_v[i] = wr & (sel == SEL_MASK) & (ctl[CH_W-1:0] == CH_W'(i));
        end
    end

    assign mode_dec  = ctl[CTL_DEC_BIT];
    assign mode_auto = ctl[CTL_AUTO_BIT];
    assign mask_val  = ctl[CTL_MASK_BIT];

    // Byte pointer: clear/set commands win over the access toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr || ptr_clr) ptr_hi <= 1'b0;
        else if (ptr_set)              ptr_hi <= 1'b1;
        else if (chan_acc)             ptr_hi <= ~ptr_hi;
    end

    // Command register: memory-to-memory enable and source hold.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            cmd_m2m  <= 1'b0;
            cmd_hold <= 1'b0;
        end else if (wr && sel == SEL_CMD) begin
            cmd_m2m  <= ctl[0];
            cmd_hold <= ctl[1];
        end
    end

    // R3
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_acc |=> ptr_hi != $past(ptr_hi));
    // R1
    mclr_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> !ptr_hi && !cmd_m2m && !cmd_hold);
endmodule

// File: rtl/dmac_chan.sv
// One channel: start/working address and count, mode bits, mask and
// terminal-count bit. Steps on a transfer pulse; reloads on auto mode.
// Assumes host writes and steps never occur in the same cycle.
module dmac_chan
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              ptr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_wr,
    input  logic              mode_dec,
    input  logic              mode_auto,
    input  logic              mask_wr,
    input  logic              mask_val,
    input  logic              tc_clr,
    input  logic              step,
    input  logic              ext_eop,
    input  logic              src_mode,
    input  logic              hold_addr,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_cnt,
    output logic              mask,
    output logic              tc,
    output logic              eop_p,
    output logic              page_p
);
    logic [REG_W-1:0] base_addr, base_cnt;
    logic [REG_W-1:0] step_addr, next_addr, next_cnt;
    logic dec_q, auto_q;
    logic wrap, end_svc, reload, host_act;

    // Work out the post-step address and count, including reload.
    always_comb begin
        wrap      = (cur_cnt == '0);
        end_svc   = src_mode ? 1'b0 : (wrap | ext_eop);
        reload    = auto_q & (src_mode ? wrap : end_svc);
        step_addr = hold_addr ? cur_addr : (dec_q ? cur_addr - 1'b1 : cur_addr + 1'b1);
        next_addr = reload ? base_addr : step_addr;
        next_cnt  = reload ? base_cnt  : cur_cnt - 1'b1;
        host_act  = wr_addr | wr_cnt | mclr | mode_wr | mask_wr | tc_clr;
    end

    // Address registers: host byte writes load start and working together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            if (ptr_hi) begin
                base_addr <= {wdata, base_addr[BYTE_W-1:0]};
                cur_addr  <= {wdata, base_addr[BYTE_W-1:0]};
            end else begin
                base_addr <= {base_addr[REG_W-1:BYTE_W], wdata};
                cur_addr  <= {base_addr[REG_W-1:BYTE_W], wdata};
            end
        end else if (step) begin
            cur_addr <= next_addr;
        end
    end

    // Count registers: same loading rule as the address pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            if (ptr_hi) begin
                base_cnt <= {wdata, base_cnt[BYTE_W-1:0]};
                cur_cnt  <= {wdata, base_cnt[BYTE_W-1:0]};
            end else begin
                base_cnt <= {base_cnt[REG_W-1:BYTE_W], wdata};
                cur_cnt  <= {base_cnt[REG_W-1:BYTE_W], wdata};
            end
        end else if (step) begin
            cur_cnt <= next_cnt;
        end
    end

    // Mode bits: direction and auto-reload.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            dec_q  <= 1'b0;
            auto_q <= 1'b0;
        end else if (mode_wr) begin
            dec_q  <= mode_dec;
            auto_q <= mode_auto;
        end
    end

    // Mask and terminal-count status; events set, host commands clear.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            mask <= 1'b1;
            tc   <= 1'b0;
        end else begin
            if (step && end_svc && !auto_q) mask <= 1'b1;
            else if (mask_wr)               mask <= mask_val;
            if (step && wrap && !src_mode)  tc <= 1'b1;
            else if (tc_clr)                tc <= 1'b0;
        end
    end

    // One-cycle event pulses for the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_p  <= 1'b0;
            page_p <= 1'b0;
        end else begin
            eop_p  <= step & wrap & ~src_mode;
            page_p <= step & (next_addr[REG_W-1:BYTE_W] != cur_addr[REG_W-1:BYTE_W]);
        end
    end

    // R4
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && cur_cnt != '0 && !ext_eop && !host_act
        |=> cur_cnt == REG_W'($past(cur_cnt) - 1'b1));
    // R4
    addr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && cur_cnt != '0 && !ext_eop && !host_act && !dec_q && !hold_addr
        |=> cur_addr == REG_W'($past(cur_addr) + 1'b1));
    // R5
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && cur_cnt == '0 && !src_mode && !host_act |=> tc && eop_p);
    // R6
    end_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && (cur_cnt == '0 || ext_eop) && !src_mode && !auto_q && !host_act |=> mask);
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && (cur_cnt == '0 || ext_eop) && !src_mode && auto_q && !host_act
        |=> cur_addr == base_addr && cur_cnt == base_cnt && $stable(mask));
    // R9
    src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && src_mode && !host_act |=> !eop_p && $stable(mask) && $stable(tc));
    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && hold_addr && cur_cnt != '0 && !host_act |=> $stable(cur_addr));
endmodule

// File: rtl/dmac_addr_count_unit.sv
// Top of the DMA address/count unit: host decode, one channel instance
// per DMA channel, host read mux and merged event outputs.
// Assumes the sequencer steps at most one channel per cycle.
module dmac_addr_count_unit
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              xfer_step,
    input  logic [1:0]        xfer_ch,
    input  logic              xfer_ext_eop,
    output logic [15:0]       cur_addr_o,
    output logic [3:0]        chan_mask_o,
    output logic              eop_o,
    output logic              page_o
);
    logic ptr_hi, mclr, tc_clr, cmd_m2m, cmd_hold;
    logic mode_dec, mode_auto, mask_val;
    logic [NUM_CH-1:0] wr_addr_v, wr_cnt_v, mode_wr_v, mask_wr_v;
    logic [NUM_CH-1:0] mask_v, tc_v, eop_v, page_v;
    logic [REG_W-1:0]  addr_a [NUM_CH];
    logic [REG_W-1:0]  cnt_a  [NUM_CH];
    logic [REG_W-1:0]  rd_reg;

    dmac_host_if u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (host_sel),
        .wr        (host_wr),
        .rd        (host_rd),
        .ctl       (host_wdata[CTL_W-1:0]),
        .ptr_hi    (ptr_hi),
        .mclr      (mclr),
        .tc_clr    (tc_clr),
        .cmd_m2m   (cmd_m2m),
        .cmd_hold  (cmd_hold),
        .wr_addr_v (wr_addr_v),
        .wr_cnt_v  (wr_cnt_v),
        .mode_wr_v (mode_wr_v),
        .mask_wr_v (mask_wr_v),
        .mode_dec  (mode_dec),
        .mode_auto (mode_auto),
        .mask_val  (mask_val)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic src_mode, hold_addr;
        if (g == 0) begin : g_src
            assign src_mode  = cmd_m2m;
            assign hold_addr = cmd_m2m & cmd_hold;
        end else begin : g_plain
            assign src_mode  = 1'b0;
            assign hold_addr = 1'b0;
        end

        dmac_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .mclr      (mclr),
            .wr_addr   (wr_addr_v[g]),
            .wr_cnt    (wr_cnt_v[g]),
            .ptr_hi    (ptr_hi),
            .wdata     (host_wdata),
            .mode_wr   (mode_wr_v[g]),
            .mode_dec  (mode_dec),
            .mode_auto (mode_auto),
            .mask_wr   (mask_wr_v[g]),
            .mask_val  (mask_val),
            .tc_clr    (tc_clr),
            .step      (xfer_step && xfer_ch == CH_W'(g)),
            .ext_eop   (xfer_ext_eop),
            .src_mode  (src_mode),
            .hold_addr (hold_addr),
            .cur_addr  (addr_a[g]),
            .cur_cnt   (cnt_a[g]),
            .mask      (mask_v[g]),
            .tc        (tc_v[g]),
            .eop_p     (eop_v[g]),
            .page_p    (page_v[g])
        );
    end

    // Host read mux: channel register byte or status.
    always_comb begin
        rd_reg = host_sel[0] ? cnt_a[host_sel[CH_W:1]] : addr_a[host_sel[CH_W:1]];
        if (!host_sel[SEL_W-1])
            host_rdata = ptr_hi ? rd_reg[REG_W-1:BYTE_W] : rd_reg[BYTE_W-1:0];
        else if (host_sel == SEL_MASK)
            host_rdata = {mask_v, tc_v};
        else
            host_rdata = '0;
    end

    assign cur_addr_o  = addr_a[xfer_ch];
    assign chan_mask_o = mask_v;
    assign eop_o       = |eop_v;
    assign page_o      = |page_v;

    // R5
    eop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eop_v));
    // R11
    page_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_o |-> $past(xfer_step));
endmodule

// File: tb/dmac_addr_count_unit_tb_top.sv
module dmac_addr_count_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] host_sel = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic xfer_step = 1'b0, xfer_ext_eop = 1'b0;
    logic [1:0] xfer_ch = '0;
    logic [15:0] cur_addr_o;
    logic [3:0] chan_mask_o;
    logic eop_o, page_o;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    dmac_addr_count_unit dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_step(xfer_step), .xfer_ch(xfer_ch), .xfer_ext_eop(xfer_ext_eop),
        .cur_addr_o(cur_addr_o), .chan_mask_o(chan_mask_o),
        .eop_o(eop_o), .page_o(page_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic hwr(input logic [3:0] s, input logic [7:0] d);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [3:0] s, output logic [7:0] d);
        host_sel = s; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic hrd16(input logic [3:0] s, output logic [15:0] v);
        logic [7:0] lo, hi;
        hrd(s, lo);
        hrd(s, hi);
        v = {hi, lo};
    endtask

    task automatic prog(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c);
        hwr({1'b0, ch, 1'b0}, a[7:0]);
        hwr({1'b0, ch, 1'b0}, a[15:8]);
        hwr({1'b0, ch, 1'b1}, c[7:0]);
        hwr({1'b0, ch, 1'b1}, c[15:8]);
    endtask

    task automatic stepx(input logic [1:0] ch, input logic e, output logic eo, output logic pg);
        xfer_ch = ch; xfer_ext_eop = e; xfer_step = 1'b1;
        @(negedge clk);
        xfer_step = 1'b0; xfer_ext_eop = 1'b0;
        eo = eop_o; pg = page_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [15:0] v, ea, ec, ba, bc, na;
        logic eo, pg, ewrap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mask after reset", chan_mask_o, 4'hF);
        chk("R1 eop after reset", eop_o, 0);
        chk("R1 page after reset", page_o, 0);
        hrd(4'hD, d);
        chk("R1 R12 status after reset", d, 8'hF0);

        // R2 R3 write then read back
        prog(2'd1, 16'hBEEF, 16'h1234);
        hrd16(4'h2, v);
        chk("R2 address readback", v, 16'hBEEF);
        hrd16(4'h3, v);
        chk("R2 count readback", v, 16'h1234);

        // Sweep channels, directions and reload settings
        for (int ch = 0; ch < 4; ch++) begin
            for (int dec = 0; dec < 2; dec++) begin
                for (int au = 0; au < 2; au++) begin
                    hwr(4'hC, 8'h00);
                    ba = (dec != 0) ? 16'h0301 + 16'(ch * 256) : 16'h02FE + 16'(ch * 256);
                    bc = 16'(ch + 2);
                    prog(2'(ch), ba, bc);
                    hwr(4'h8, {3'b000, 1'(au), 1'(dec), 1'b0, 2'(ch)});
                    hwr(4'hD, {5'b0, 1'b0, 2'(ch)});
                    ea = ba; ec = bc;
                    for (int s = 0; s < ch + 5; s++) begin
                        ewrap = (ec == 16'h0000);
                        na = (dec != 0) ? ea - 16'd1 : ea + 16'd1;
                        if (ewrap && au != 0) begin
                            na = ba; v = bc;
                        end else begin
                            v = ec - 16'd1;
                        end
                        stepx(2'(ch), 1'b0, eo, pg);
                        chk("R4 R7 address after step", cur_addr_o, na);
                        chk("R5 eop pulse", eo, ewrap);
                        chk("R11 page pulse", pg, (na[15:8] != ea[15:8]));
                        ea = na; ec = v;
                    end
                    hrd16({1'b0, 2'(ch), 1'b1}, v);
                    chk("R4 R5 R7 count after run", v, ec);
                    hrd(4'hD, d);
                    chk("R6 R7 R12 status after run", d,
                        {(au != 0) ? (4'hF & ~(4'b1 << ch)) : 4'hF, 4'b1 << ch});
                    hrd(4'hD, d);
                    chk("R12 tc cleared by read", d[3:0], 4'h0);
                end
            end
        end

        // R8 external end-of-process, no reload
        hwr(4'hC, 8'h00);
        prog(2'd2, 16'h7000, 16'd10);
        hwr(4'hD, 8'h02);
        chk("R13 unmask", chan_mask_o, 4'hB);
        stepx(2'd2, 1'b1, eo, pg);
        chk("R8 no eop on external end", eo, 0);
        chk("R8 address still stepped", cur_addr_o, 16'h7001);
        hrd(4'hD, d);
        chk("R8 R6 mask set, tc clear", d, 8'hF0);
        hrd16(4'h5, v);
        chk("R8 count stepped", v, 16'd9);

        // R8 R7 external end with reload
        hwr(4'h8, 8'h12);
        hwr(4'hD, 8'h02);
        stepx(2'd2, 1'b0, eo, pg);
        stepx(2'd2, 1'b0, eo, pg);
        chk("R4 two steps", cur_addr_o, 16'h7003);
        stepx(2'd2, 1'b1, eo, pg);
        chk("R8 R7 reload address", cur_addr_o, 16'h7000);
        chk("R7 mask unchanged", chan_mask_o, 4'hB);
        hrd16(4'h5, v);
        chk("R7 reload count", v, 16'd10);

        // R9 R10 memory-to-memory source channel
        hwr(4'hC, 8'h00);
        prog(2'd0, 16'h40FF, 16'd2);
        prog(2'd1, 16'h5000, 16'd5);
        hwr(4'h8, 8'h10);
        hwr(4'h9, 8'h03);
        hwr(4'hD, 8'h00);
        hwr(4'hD, 8'h01);
        for (int s = 0; s < 3; s++) begin
            stepx(2'd0, 1'b0, eo, pg);
            chk("R10 source address held", cur_addr_o, 16'h40FF);
            chk("R9 no eop from source", eo, 0);
        end
        hrd16(4'h1, v);
        chk("R9 source reloaded at wrap", v, 16'd2);
        stepx(2'd0, 1'b1, eo, pg);
        hrd16(4'h1, v);
        chk("R9 external eop ignored on source", v, 16'd1);
        hrd(4'hD, d);
        chk("R9 source no mask, no tc", d, 8'hC0);
        stepx(2'd1, 1'b1, eo, pg);
        chk("R8 destination ends on external", chan_mask_o, 4'hE);
        hwr(4'h9, 8'h01);
        stepx(2'd0, 1'b0, eo, pg);
        chk("R10 no hold increments", cur_addr_o, 16'h4100);
        chk("R11 page on source step", pg, 1);

        // R3 pointer commands, R1 master clear
        hwr(4'hB, 8'h00);
        hrd(4'h2, d);
        chk("R3 set pointer reads high", d, 8'h50);
        hrd(4'h2, d);
        chk("R3 toggle reads low", d, 8'h01);
        hwr(4'hB, 8'h00);
        hwr(4'hA, 8'h00);
        hrd(4'h2, d);
        chk("R3 clear pointer reads low", d, 8'h01);
        hwr(4'hC, 8'h00);
        chk("R1 master clear masks", chan_mask_o, 4'hF);
        hrd(4'h2, d);
        chk("R1 master clear pointer low", d, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule